// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a clocked static RAM in which each word has a nonvolatile shadow word beside it. While the block is in SRAM mode, the host reads and writes the array through a chip-select, write-strobe and output-enable port. These accesses never touch the shadow. While the block is in transfer mode, it copies the whole array in one step, in one of two directions. A STORE copies the SRAM into the shadow. A RECALL first clears the SRAM and then copies the shadow back into it.

A STORE starts on a rising edge of the power-fail input, or when a software key sequence ends in the store address. A RECALL starts when reset is released (power-up), or when a software key sequence ends in the recall address. The key sequence is six consecutive reads on the normal port. For as long as a transfer runs, `busy_o` is high, the port ignores every access and the read bus is released. The array depth is set by `ADDR_W`. The default of 10 gives 1024 words, and `ADDR_W = 15` gives the full 32768-word array.

Top module: `nvsram_ctrl`

## Requirements
- R1: In SRAM mode, an access with `ce_n_i` low and `we_n_i` low writes `wdata_i` to `addr_i` at the clock edge. An access with `ce_n_i` low and `we_n_i` high is a read. For a read, the word and `data_oe_o` appear one cycle later, and a repeated read returns the same word.
- R2: A read made with `oe_n_i` high leaves `data_oe_o` low. Whenever `data_oe_o` is low, `rdata_o` is zero.
- R3: A rising edge of `pwr_fail_i` in SRAM mode raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `STORE_CYC` cycles. Any access made while `pwr_fail_i` is high is ignored.
- R4: A STORE copies every SRAM word into its shadow word. A later RECALL shows the stored values.
- R5: `busy_o` is high during reset. After reset is released, a power-up RECALL keeps `busy_o` high for `CLR_CYC + CPY_CYC` cycles, and no access is served before that RECALL ends.
- R6: A RECALL clears the SRAM and then loads it from the shadow. The shadow is never changed by a RECALL, so two RECALLs in a row give the same data.
- R7: Six consecutive reads form the key sequence. The first five go to `SEQ_A0`..`SEQ_A4` (defaults 0x0E3, 0x38C, 0x1C7, 0x25A, 0x0B4). A sixth read of `SEQ_STORE` (default 0x3F0) starts a STORE, and a sixth read of `SEQ_RECALL` (default 0x00F) starts a RECALL. The transfer begins in the cycle after the sixth read, and that read's data is not driven. The first five reads return ordinary SRAM data.
- R8: A write, or a read of any address other than the next expected one, aborts the sequence. A mismatching read of `SEQ_A0` counts as a new first step.
- R9: While `busy_o` is high, writes and reads are ignored and `data_oe_o` stays low.
- R10: If `pwr_fail_i` is asserted during a key sequence, the sequence is dropped and the automatic STORE runs. If `pwr_fail_i` is asserted during a running STORE, that STORE neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release is treated as power-up |
| pwr_fail_i | input | 1 | Power-fail warning, high active |
| ce_n_i | input | 1 | Chip enable, low active |
| we_n_i | input | 1 | Write enable, low active |
| oe_n_i | input | 1 | Output enable, low active |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Read bus drive enable |
| busy_o | output | 1 | Transfer in progress |

## Verification
Suppose the key-sequence step counter holds a wrong value. The fault shows as a transfer that starts, or fails to start, in the cycle after a sixth read, so `busy_o` is wrong one cycle after the faulty access. A wrong transfer counter or phase shows as a `busy_o` pulse of the wrong length, which becomes visible on the cycle `busy_o` falls. A wrong copy or clear is hidden until a later read. For that reason, every transfer is followed by reads of known words, and STORE data is proven by a RECALL or a power cycle afterwards.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      NVS_SRAM    = 2'd0,
      NVS_STORE   = 2'd1,
      NVS_RCL_CLR = 2'd2,
      NVS_RCL_CPY = 2'd3
   } nvs_mode_e;

   localparam int NVS_KEY_LEN = 6;
   localparam int NVS_STEP_W  = 3;
endpackage

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              do_store,
   input  logic              do_clear,
   input  logic              do_copy,
   output logic [DATA_W-1:0] rd_word
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] live   [WORDS];
   logic [DATA_W-1:0] shadow [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (do_clear)
            live[w] <= '0;
         else if (do_copy)
            live[w] <= shadow[w];
         else if (wr_en && addr == ADDR_W'(w))
            live[w] <= wdata;
      end

      always_ff @(posedge clk) begin
         if (do_store)
            shadow[w] <= live[w];
      end
   end

   assign rd_word = live[addr];
endmodule

// File: rtl/nvs_key_seq.sv
module nvs_key_seq
   import nvs_pkg::*;
#(
   parameter int                ADDR_W     = 10,
   parameter logic [ADDR_W-1:0] SEQ_A0     = 'h0E3,
   parameter logic [ADDR_W-1:0] SEQ_A1     = 'h38C,
   parameter logic [ADDR_W-1:0] SEQ_A2     = 'h1C7,
   parameter logic [ADDR_W-1:0] SEQ_A3     = 'h25A,
   parameter logic [ADDR_W-1:0] SEQ_A4     = 'h0B4,
   parameter logic [ADDR_W-1:0] SEQ_STORE  = 'h3F0,
   parameter logic [ADDR_W-1:0] SEQ_RECALL = 'h00F
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  rd_acc,
   input  logic                  wr_acc,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  sw_store,
   output logic                  sw_recall,
   output logic [NVS_STEP_W-1:0] step_o
);
   localparam logic [NVS_STEP_W-1:0] LAST = NVS_STEP_W'(NVS_KEY_LEN - 1);

   logic [NVS_STEP_W-1:0] step;
   logic [ADDR_W-1:0]     want;
   logic                  hit;

   always_comb begin
      unique case (step)
         3'd0:    want = SEQ_A0;
         3'd1:    want = SEQ_A1;
         3'd2:    want = SEQ_A2;
         3'd3:    want = SEQ_A3;
         default: want = SEQ_A4;
      endcase
   end

   assign hit       = rd_acc && (step < LAST) && (addr == want);
   assign sw_store  = rd_acc && (step == LAST) && (addr == SEQ_STORE);
   assign sw_recall = rd_acc && (step == LAST) && (addr == SEQ_RECALL);
   assign step_o    = step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         step <= '0;
      else if (flush)
         step <= '0;
      else if (rd_acc || wr_acc) begin
         if (hit)
            step <= step + 1'b1;
         else if (rd_acc && addr == SEQ_A0)
            step <= NVS_STEP_W'(1);
         else
            step <= '0;
      end
   end
endmodule

// File: rtl/nvs_xfer_ctl.sv
module nvs_xfer_ctl
   import nvs_pkg::*;
#(
   parameter int STORE_CYC = 64,
   parameter int CLR_CYC   = 8,
   parameter int CPY_CYC   = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pf_go,
   input  logic      sw_store,
   input  logic      sw_recall,
   output nvs_mode_e mode,
   output logic      busy,
   output logic      do_store,
   output logic      do_clear,
   output logic      do_copy
);
   localparam int MAX_CYC = (STORE_CYC > CLR_CYC) ?
                            ((STORE_CYC > CPY_CYC) ? STORE_CYC : CPY_CYC) :
                            ((CLR_CYC > CPY_CYC) ? CLR_CYC : CPY_CYC);
   localparam int CNT_W = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] ST_LOAD = CNT_W'(STORE_CYC - 1);
   localparam logic [CNT_W-1:0] CL_LOAD = CNT_W'(CLR_CYC - 1);
   localparam logic [CNT_W-1:0] CP_LOAD = CNT_W'(CPY_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= NVS_RCL_CLR;
         cnt  <= CL_LOAD;
      end else begin
         unique case (mode)
            NVS_SRAM: begin
               if (pf_go || sw_store) begin
                  mode <= NVS_STORE;
                  cnt  <= ST_LOAD;
               end else if (sw_recall) begin
                  mode <= NVS_RCL_CLR;
                  cnt  <= CL_LOAD;
               end
            end
            NVS_STORE: begin
               if (cnt == '0) mode <= NVS_SRAM;
               else           cnt  <= cnt - 1'b1;
            end
            NVS_RCL_CLR: begin
               if (cnt == '0) begin
                  mode <= NVS_RCL_CPY;
                  cnt  <= CP_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (cnt == '0) mode <= NVS_SRAM;
               else           cnt  <= cnt - 1'b1;
            end
         endcase
      end
   end

   assign busy     = (mode != NVS_SRAM);
   assign do_store = (mode == NVS_STORE)   && (cnt == ST_LOAD);
   assign do_clear = (mode == NVS_RCL_CLR) && (cnt == CL_LOAD);
   assign do_copy  = (mode == NVS_RCL_CPY) && (cnt == CP_LOAD);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
   import nvs_pkg::*;
#(
   parameter int                ADDR_W     = 10,
   parameter int                DATA_W     = 8,
   parameter int                STORE_CYC  = 64,
   parameter int                CLR_CYC    = 8,
   parameter int                CPY_CYC    = 32,
   parameter bit                SW_SEQ_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] SEQ_A0     = 'h0E3,
   parameter logic [ADDR_W-1:0] SEQ_A1     = 'h38C,
   parameter logic [ADDR_W-1:0] SEQ_A2     = 'h1C7,
   parameter logic [ADDR_W-1:0] SEQ_A3     = 'h25A,
   parameter logic [ADDR_W-1:0] SEQ_A4     = 'h0B4,
   parameter logic [ADDR_W-1:0] SEQ_STORE  = 'h3F0,
   parameter logic [ADDR_W-1:0] SEQ_RECALL = 'h00F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail_i,
   input  logic              ce_n_i,
   input  logic              we_n_i,
   input  logic              oe_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              data_oe_o,
   output logic              busy_o
);
   if (ADDR_W < 4 || ADDR_W > 15) begin : g_bad_aw
      $error("nvsram_ctrl: ADDR_W out of range 4..15");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("nvsram_ctrl: DATA_W must be positive");
   end
   if (STORE_CYC < 1 || CLR_CYC < 1 || CPY_CYC < 1) begin : g_bad_cyc
      $error("nvsram_ctrl: transfer cycle counts must be at least 1");
   end
   if (SEQ_STORE == SEQ_RECALL) begin : g_bad_key
      $error("nvsram_ctrl: store and recall key addresses must differ");
   end

   nvs_mode_e             mode;
   logic                  busy;
   logic                  do_store, do_clear, do_copy;
   logic                  acc, rd_acc, wr_acc;
   logic                  pf_q, pf_pend, pf_rise, pf_go;
   logic                  sw_store, sw_recall;
   logic [NVS_STEP_W-1:0] seq_step;
   logic [DATA_W-1:0]     cell_rd;
   logic [DATA_W-1:0]     rdata_q;
   logic                  oe_q;

   // Host access only in SRAM mode and only while power is good.
   assign acc    = !ce_n_i && !busy && !pwr_fail_i;
   assign rd_acc = acc && we_n_i;
   assign wr_acc = acc && !we_n_i;

   // Power-fail edge is remembered until SRAM mode allows the STORE.
   assign pf_rise = pwr_fail_i && !pf_q;
   assign pf_go   = (mode == NVS_SRAM) && (pf_rise || pf_pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_q    <= 1'b0;
         pf_pend <= 1'b0;
      end else begin
         pf_q <= pwr_fail_i;
         if (mode == NVS_STORE || pf_go)
            pf_pend <= 1'b0;
         else if (pf_rise)
            pf_pend <= 1'b1;
      end
   end

   if (SW_SEQ_EN) begin : g_key
      nvs_key_seq #(
         .ADDR_W    (ADDR_W),
         .SEQ_A0    (SEQ_A0),
         .SEQ_A1    (SEQ_A1),
         .SEQ_A2    (SEQ_A2),
         .SEQ_A3    (SEQ_A3),
         .SEQ_A4    (SEQ_A4),
         .SEQ_STORE (SEQ_STORE),
         .SEQ_RECALL(SEQ_RECALL)
      ) u_key (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (pwr_fail_i),
         .rd_acc   (rd_acc),
         .wr_acc   (wr_acc),
         .addr     (addr_i),
         .sw_store (sw_store),
         .sw_recall(sw_recall),
         .step_o   (seq_step)
      );
   end else begin : g_nokey
      assign sw_store  = 1'b0;
      assign sw_recall = 1'b0;
      assign seq_step  = '0;
   end

   nvs_xfer_ctl #(
      .STORE_CYC(STORE_CYC),
      .CLR_CYC  (CLR_CYC),
      .CPY_CYC  (CPY_CYC)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pf_go    (pf_go),
      .sw_store (sw_store),
      .sw_recall(sw_recall),
      .mode     (mode),
      .busy     (busy),
      .do_store (do_store),
      .do_clear (do_clear),
      .do_copy  (do_copy)
   );

   nvs_cell_array #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_cells (
      .clk     (clk),
      .wr_en   (wr_acc),
      .addr    (addr_i),
      .wdata   (wdata_i),
      .do_store(do_store),
      .do_clear(do_clear),
      .do_copy (do_copy),
      .rd_word (cell_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         oe_q    <= 1'b0;
      end else begin
         if (rd_acc)
            rdata_q <= cell_rd;
         oe_q <= rd_acc && !oe_n_i;
      end
   end

   assign busy_o    = busy;
   assign data_oe_o = oe_q && !busy;
   assign rdata_o   = data_oe_o ? rdata_q : '0;
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
   parameter int DATA_W    = 8,
   parameter int STORE_CYC = 64,
   parameter int CLR_CYC   = 8,
   parameter int CPY_CYC   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_fail_i,
   input logic              busy_o,
   input logic              data_oe_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic [2:0]        seq_step
);
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= 0;
      else if (busy_o) run_len <= run_len + 1;
      else             run_len <= 0;
   end

   // R9
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !data_oe_o);

   // R2
   undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe_o |-> (rdata_o == '0));

   // R3
   pf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail_i && !$past(pwr_fail_i) && !busy_o) |=> busy_o);

   // R3 R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == STORE_CYC || run_len == CLR_CYC + CPY_CYC));

   // R10
   pf_drop_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail_i |=> (seq_step == 3'd0));

   // R7
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_step <= 3'd5);
endmodule

bind nvsram_ctrl nvs_chk #(
   .DATA_W   (DATA_W),
   .STORE_CYC(STORE_CYC),
   .CLR_CYC  (CLR_CYC),
   .CPY_CYC  (CPY_CYC)
) u_nvs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_fail_i(pwr_fail_i),
   .busy_o    (busy_o),
   .data_oe_o (data_oe_o),
   .rdata_o   (rdata_o),
   .seq_step  (seq_step)
);

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int ST_N = 12;
   localparam int CL_N = 4;
   localparam int CP_N = 6;
   localparam logic [AW-1:0] K0 = 'h0E3, K1 = 'h38C, K2 = 'h1C7,
                             K3 = 'h25A, K4 = 'h0B4, KST = 'h3F0, KRC = 'h00F;

   logic clk = 1'b0, rst_n = 1'b0, pwr_fail = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic data_oe, busy;

   nvsram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .STORE_CYC(ST_N), .CLR_CYC(CL_N), .CPY_CYC(CP_N),
      .SW_SEQ_EN(1'b1), .SEQ_A0(K0), .SEQ_A1(K1), .SEQ_A2(K2), .SEQ_A3(K3),
      .SEQ_A4(K4), .SEQ_STORE(KST), .SEQ_RECALL(KRC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .ce_n_i(ce_n),
      .we_n_i(we_n), .oe_n_i(oe_n), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .data_oe_o(data_oe), .busy_o(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [DW-1:0] d;
      logic          oe;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   n_run = 0, n_fail = 0;
   logic chk_flag = 1'b0;
   logic mon_f;
   bit   done = 0;

   task automatic check_eq(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per flagged read, one cycle after it.
   always begin
      @(posedge clk);
      mon_f = chk_flag;
      #1;
      if (mon_f) begin
         if (sb.size() == 0) begin
            check_eq("monitor queue empty", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check_eq({e.tag, " oe"}, int'(data_oe), int'(e.oe));
            check_eq({e.tag, " data"}, int'(rdata), int'(e.d));
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; chk_flag = 1'b0; pwr_fail = 1'b0;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d; chk_flag = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [DW-1:0] d, logic oe_exp,
                     bit chk, string tag, logic oen = 1'b0);
      exp_t e;
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = oen; addr = a; chk_flag = chk;
      if (chk) begin
         e.d = oe_exp ? d : '0; e.oe = oe_exp; e.tag = tag;
         sb.push_back(e);
      end
   endtask

   task automatic key(logic [AW-1:0] last);
      rd(K0, 0, 0, 0, ""); rd(K1, 0, 0, 0, ""); rd(K2, 0, 0, 0, "");
      rd(K3, 0, 0, 0, ""); rd(K4, 0, 0, 0, ""); rd(last, 0, 0, 0, "");
      idle();
   endtask

   // Counts cycles with busy high, starting at the current negedge.
   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic quiet(string tag);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_eq(tag, int'(busy), 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      // R5: reset state and power-up recall
      repeat (3) @(negedge clk);
      check_eq("R5 busy in reset", int'(busy), 1);
      check_eq("R2 no drive in reset", int'(data_oe), 0);
      rst_n = 1'b1;
      busy_len(n);
      check_eq("R5 power-up recall length", n, CL_N + CP_N);

      // R1: plain write/read
      wr(5, 8'hA5); wr(6, 8'h3C);
      rd(5, 8'hA5, 1, 1, "R1 read 5");
      rd(6, 8'h3C, 1, 1, "R1 read 6");
      rd(5, 8'hA5, 1, 1, "R1 repeat read 5");
      // R2: read with output enable off
      rd(5, 8'hA5, 0, 1, "R2 oe_n high", 1'b1);
      idle();

      // R3: power-fail store
      @(negedge clk); pwr_fail = 1'b1;
      idle();
      busy_len(n);
      check_eq("R3 store length", n, ST_N);

      // R9: accesses during busy are ignored
      @(negedge clk); pwr_fail = 1'b1;
      wr(5, 8'hFF);
      pwr_fail = 1'b0;
      wr(5, 8'hFF);
      rd(5, 8'h00, 0, 1, "R9 read while busy");
      idle();
      busy_len(n);
      rd(5, 8'hA5, 1, 1, "R9 write while busy ignored");
      idle();

      // R7 R4: software recall, sequence reads return ordinary data
      wr(5, 8'h11); wr(K0, 8'h5A);
      rd(K0, 8'h5A, 1, 1, "R7 key read data");
      rd(K1, 0, 0, 0, ""); rd(K2, 0, 0, 0, ""); rd(K3, 0, 0, 0, "");
      rd(K4, 0, 0, 0, ""); rd(KRC, 0, 0, 0, "");
      idle();
      busy_len(n);
      check_eq("R7 recall length", n, CL_N + CP_N);
      rd(5, 8'hA5, 1, 1, "R4 recalled word 5");
      rd(6, 8'h3C, 1, 1, "R4 recalled word 6");
      idle();

      // R6: second recall gives same data
      wr(5, 8'h22);
      key(KRC);
      busy_len(n);
      rd(5, 8'hA5, 1, 1, "R6 shadow unchanged by recall");
      idle();

      // R8: abort by write, abort by wrong read
      rd(K0, 0, 0, 0, ""); rd(K1, 0, 0, 0, ""); rd(K2, 0, 0, 0, "");
      wr(100, 8'h44);
      rd(K3, 0, 0, 0, ""); rd(K4, 0, 0, 0, ""); rd(KRC, 0, 0, 0, "");
      idle();
      quiet("R8 write aborts key");
      rd(K0, 0, 0, 0, ""); rd(K1, 0, 0, 0, ""); rd(7, 0, 0, 0, "");
      rd(K2, 0, 0, 0, ""); rd(K3, 0, 0, 0, ""); rd(K4, 0, 0, 0, "");
      rd(KST, 0, 0, 0, "");
      idle();
      quiet("R8 wrong read aborts key");
      rd(100, 8'h44, 1, 1, "R8 data intact");
      idle();

      // R8 R7: restart on K0, sequence then stores
      wr(5, 8'h66);
      rd(K0, 0, 0, 0, ""); rd(K1, 0, 0, 0, "");
      key(KST);
      busy_len(n);
      check_eq("R8 restart then store length", n, ST_N);
      wr(5, 8'h77);
      idle();

      // R5 R4: power cycle recalls stored word
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check_eq("R5 busy in second reset", int'(busy), 1);
      rst_n = 1'b1;
      busy_len(n);
      check_eq("R5 recall after power cycle", n, CL_N + CP_N);
      rd(5, 8'h66, 1, 1, "R4 software store survived power cycle");
      idle();

      // R10: power-fail during a key sequence
      wr(5, 8'h88);
      rd(K0, 0, 0, 0, ""); rd(K1, 0, 0, 0, ""); rd(K2, 0, 0, 0, "");
      rd(K3, 0, 0, 0, "");
      @(negedge clk); ce_n = 1'b1; pwr_fail = 1'b1;
      idle();
      busy_len(n);
      check_eq("R10 power-fail store during key", n, ST_N);
      rd(K4, 0, 0, 0, ""); rd(KST, 0, 0, 0, "");
      idle();
      quiet("R10 key dropped");
      wr(5, 8'h99);
      key(KRC);
      busy_len(n);
      rd(5, 8'h88, 1, 1, "R10 automatic store captured data");
      idle();

      // R10: power-fail during running store does not extend it
      wr(5, 8'hAB);
      key(KST);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         pwr_fail = (n == 3);
         @(negedge clk);
      end
      pwr_fail = 1'b0;
      check_eq("R10 store not extended", n, ST_N);
      quiet("R10 no second store");

      repeat (3) @(negedge clk);
      check_eq("monitor drained", sb.size(), 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule